// File: doc/BRIEF.md
# Double-Buffered Serial Block Transmitter

This block sends a block of 12-bit words on a single serial line, most significant bit first. A host places each word in a holding register. On the last bit of the word now going out, the block moves the held word into its shift register, so consecutive words leave back to back with no idle bit between them. Every block starts with a fixed sync word. A cyclic check code is built over the data bits and sent as the final word.

The host writes only when the holding register reports empty. It marks the end of a block by leaving the holding register empty at a word boundary. The block then sends the accumulated check code, drops busy, and pulses done. One bit moves for each single-cycle assertion of the bit-rate enable, so the caller sets the line rate. About 25 µs per bit gives roughly 300 µs per word.

Top module: `ser_block_tx`

## Requirements
- R1: After reset, and whenever not busy, `ser_out` is 1, `busy` is 0 and `hold_empty` is 1. Asserting `bit_tick` while idle changes neither `ser_out` nor `busy`.
- R2: A `start` pulse while idle sets `busy` at the next clock edge. `ser_out` then presents the sync word (default 12'h5A3) MSB first. Each `bit_tick` advances the line by exactly one bit, and the line holds between ticks.
- R3: When the tick that ends a word arrives and the holding register is full, the held word becomes the next 12 bits on the line with no gap, sent MSB first.
- R4: A write while `hold_empty` is 1 is captured, and `hold_empty` goes to 0. `hold_empty` returns to 1 at the edge where the held word moves into the shift register.
- R5: The check code is a 12-bit CRC with generator x^12+x^11+x^3+x^2+x+1 (constant 12'h80F). It starts at zero and covers only the data bits, MSB first. For each bit b: f = b XOR crc[11], then crc = (crc << 1) XOR (f ? 12'h80F : 0).
- R6: When a sync or data word ends with the holding register empty, the next 12 bits are the CRC, sent MSB first. A block with no data words therefore sends 12'h000 after the sync word.
- R7: On the tick that sends the last CRC bit, `busy` falls and `done` is high for exactly one cycle. The line then returns to 1.
- R8: A write while the holding register is full is ignored, and the held word is kept. It sets `overrun`, which stays set until the next accepted `start`.
- R9: A `start` pulse while busy is ignored, and the bit stream continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a block (taken only when idle) |
| bit_tick | input | 1 | Single-cycle bit-rate enable |
| wr_en | input | 1 | Host write strobe for the holding register |
| wr_data | input | 12 | Word to load |
| hold_empty | output | 1 | Holding register can take a word |
| overrun | output | 1 | Sticky flag for a write made while full |
| ser_out | output | 1 | Serial data line, idle high |
| busy | output | 1 | Block in progress |
| done | output | 1 | One-cycle pulse at the end of a block |

## Verification
The bench builds the block with its default 12-bit word, the default sync pattern and the default generator constant. At that width a one-word block is only 36 line bits long. This makes it cheap to sweep 64 spread data values through the CRC path and compare every bit against a check code computed in the bench. Blocks of zero to five words cover the empty-block CRC, the gapless hand-off between words, and refilling the holding register between boundaries. Separate runs inject a start while busy and a write while full.

// File: rtl/ser_block_tx.sv
module ser_block_tx #(
  parameter int          W            = 12,
  parameter logic [11:0] SYNC_PATTERN = 12'h5A3,
  parameter logic [11:0] POLY         = 12'h80F
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         bit_tick,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic         hold_empty,
  output logic         overrun,
  output logic         ser_out,
  output logic         busy,
  output logic         done
);
  localparam int CW = $clog2(W);

  typedef enum logic [1:0] {PH_SYNC, PH_DATA, PH_CRC} phase_t;

  phase_t         phase;
  logic [W-1:0]   shreg, hold, crc, crc_nxt;
  logic [CW-1:0]  bitcnt;
  logic           hold_full;

  wire go       = start & ~busy;
  wire step     = busy & bit_tick;
  wire last_bit = bitcnt == CW'(W-1);
  wire fb       = shreg[W-1] ^ crc[W-1];
  wire load     = wr_en & ~hold_full;
  wire take     = step & last_bit & (phase != PH_CRC) & hold_full;

  assign crc_nxt    = (phase == PH_DATA) ? ({crc[W-2:0], 1'b0} ^ (fb ? POLY[W-1:0] : '0)) : crc;
  assign ser_out    = busy ? shreg[W-1] : 1'b1;
  assign hold_empty = ~hold_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      phase     <= PH_SYNC;
      shreg     <= '0;
      bitcnt    <= '0;
      crc       <= '0;
      hold      <= '0;
      hold_full <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) begin
        busy   <= 1'b1;
        phase  <= PH_SYNC;
        shreg  <= SYNC_PATTERN[W-1:0];
        bitcnt <= '0;
        crc    <= '0;
      end else if (step) begin
        crc <= crc_nxt;
        if (!last_bit) begin
          shreg  <= shreg << 1;
          bitcnt <= bitcnt + 1'b1;
        end else begin
          bitcnt <= '0;
          if (phase == PH_CRC) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else if (hold_full) begin
            shreg <= hold;
            phase <= PH_DATA;
          end else begin
            shreg <= crc_nxt;
            phase <= PH_CRC;
          end
        end
      end

      if (load)      begin hold <= wr_data; hold_full <= 1'b1; end
      else if (take) hold_full <= 1'b0;

      overrun <= (go ? 1'b0 : overrun) | (wr_en & hold_full);
    end
  end
endmodule

module ser_block_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic bit_tick,
  input logic wr_en,
  input logic hold_empty,
  input logic overrun,
  input logic ser_out,
  input logic busy,
  input logic done
);
  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> ser_out); // R1
  AST_IDLE_TICK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> !busy); // R1
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy); // R2
  AST_LINE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !bit_tick |=> busy && $stable(ser_out)); // R2
  AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && hold_empty |=> !hold_empty); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R7
  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !hold_empty |=> overrun); // R8
  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overrun && !(start && !busy) |=> overrun); // R8
  AST_START_BUSY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !bit_tick |=> busy && $stable(ser_out)); // R9
endmodule

bind ser_block_tx ser_block_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .bit_tick(bit_tick), .wr_en(wr_en),
  .hold_empty(hold_empty), .overrun(overrun), .ser_out(ser_out), .busy(busy), .done(done)
);

// File: tb/tb_ser_block_tx.sv
`timescale 1ns/1ps
module tb_ser_block_tx;
  localparam logic [11:0] SYNC = 12'h5A3;
  localparam logic [11:0] GEN  = 12'h80F;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, bit_tick = 1'b0, wr_en = 1'b0;
  logic [11:0] wr_data = '0;
  logic hold_empty, overrun, ser_out, busy, done;

  int vectors = 0, errors = 0;
  logic [11:0] blk [0:7];

  always #10 clk = ~clk;

  ser_block_tx dut (
    .clk(clk), .rst_n(rst_n), .start(start), .bit_tick(bit_tick), .wr_en(wr_en),
    .wr_data(wr_data), .hold_empty(hold_empty), .overrun(overrun),
    .ser_out(ser_out), .busy(busy), .done(done)
  );

  task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick_once();
    @(negedge clk) bit_tick = 1'b1;
    @(negedge clk) bit_tick = 1'b0;
  endtask

  task automatic write_word(input logic [11:0] d);
    @(negedge clk) begin wr_en = 1'b1; wr_data = d; end
    @(negedge clk) wr_en = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  function automatic logic [11:0] crc_of(input int n);
    logic [11:0] c = '0;
    for (int w = 0; w < n; w++)
      for (int i = 11; i >= 0; i--) begin
        logic f = blk[w][i] ^ c[11];
        c = {c[10:0], 1'b0} ^ (f ? GEN : 12'h000);
      end
    return c;
  endfunction

  // preloaded: blk[0] is already in the holding register
  task automatic run_block(input int n, input bit preloaded, input bit inject_start);
    int wi = 0;
    logic [11:0] c = crc_of(n);
    if (n > 0) begin
      if (!preloaded) write_word(blk[0]);
      wi = 1;
    end
    pulse_start();
    chk("R2 busy after start", {11'b0, busy}, 12'h001);
    for (int b = 0; b < 12 * (n + 2); b++) begin
      int seg = b / 12;
      logic [11:0] w = (seg == 0) ? SYNC : (seg <= n) ? blk[seg - 1] : c;
      string rq = (seg == 0) ? "R2 sync bit" : (seg <= n) ? "R3 data bit" : "R5/R6 crc bit";
      chk(rq, {11'b0, ser_out}, {11'b0, w[11 - (b % 12)]});
      if (b > 0 && b % 12 == 0 && seg <= n)
        chk("R4 empty after hand-off", {11'b0, hold_empty}, 12'h001);
      if (inject_start && b == 17) begin
        pulse_start();
        chk("R9 start while busy", {11'b0, ser_out}, {11'b0, w[11 - (b % 12)]});
      end
      if (hold_empty && wi < n) begin
        write_word(blk[wi]);
        wi++;
        chk("R4 write captured", {11'b0, hold_empty}, 12'h000);
      end
      tick_once();
    end
    chk("R7 done pulse", {11'b0, done}, 12'h001);
    chk("R7 busy low", {11'b0, busy}, 12'h000);
    chk("R7 line idle", {11'b0, ser_out}, 12'h001);
    @(negedge clk);
    chk("R7 done one cycle", {11'b0, done}, 12'h000);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset ser_out", {11'b0, ser_out}, 12'h001);
    chk("R1 reset busy", {11'b0, busy}, 12'h000);
    chk("R1 reset hold_empty", {11'b0, hold_empty}, 12'h001);
    chk("R8 reset overrun", {11'b0, overrun}, 12'h000);
    for (int k = 0; k < 4; k++) tick_once();
    chk("R1 idle tick line", {11'b0, ser_out}, 12'h001);
    chk("R1 idle tick busy", {11'b0, busy}, 12'h000);

    run_block(0, 1'b0, 1'b0);                         // R6 empty block -> crc 000

    for (int k = 0; k < 64; k++) begin                // R5 sweep over one-word blocks
      blk[0] = 12'((k * 12'd273 + k * k * 7) & 12'hFFF);
      run_block(1, 1'b0, 1'b0);
    end
    for (int k = 0; k < 12; k++) begin                // R5 walking ones
      blk[0] = 12'h001 << k;
      run_block(1, 1'b0, 1'b0);
    end

    for (int n = 2; n <= 5; n++) begin                // R3 multi-word blocks
      for (int i = 0; i < n; i++) blk[i] = 12'((n * 12'h3C1 + i * 12'h9A7) & 12'hFFF);
      run_block(n, 1'b0, 1'b0);
    end

    blk[0] = 12'hFFF; blk[1] = 12'h000; blk[2] = 12'hA5A;
    run_block(3, 1'b0, 1'b1);                         // R9

    blk[0] = 12'h6C3;                                 // R8 overrun
    write_word(12'h6C3);
    write_word(12'h111);
    chk("R8 overrun set", {11'b0, overrun}, 12'h001);
    chk("R8 still full", {11'b0, hold_empty}, 12'h000);
    run_block(1, 1'b1, 1'b0);
    chk("R8 cleared by start", {11'b0, overrun}, 12'h000);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule